// File: doc/BRIEF.md
# Twiddle Coefficient Sequencer for One Radix-2 Pipeline Stage

This block supplies the complex twiddle factor needed by one stage of a pipelined radix-2 decimation-in-time FFT. The stage number is a parameter, `STAGE`. The stage holds `2^(STAGE-1)` coefficients, W(k) = exp(-j·2πk/2^STAGE). The real parts live in one single-port table and the imaginary parts in another. Both tables are filled at elaboration from a constant function, so no table text appears in the source.

A wrapping up-counter forms the table address. It moves forward one entry on each clock edge where `en` is high. The table read has no output register. The twiddle word on the outputs therefore belongs to the address shown on `addr_o` in that same cycle.

Both output parts are signed fixed point with `FRAC_W` (default 15) fractional bits in a `DATA_W` (default 16) bit word. Any value that would reach +1.0 is clamped to the largest positive code.

Top module: `twd_seq`

## Requirements
- R1: The address runs 0, 1, …, 2^(STAGE-1)−1 and then returns to 0. It takes one step per clock edge on which `en` is 1 and `rst` is 0.
- R2: `rst` is synchronous and active high. The clock edge that samples it at 1 sets the address to 0, whatever `en` is.
- R3: On an edge where `en` is 0 and `rst` is 0, the address keeps its value, and so do both twiddle outputs.
- R4: `tw_re_o` equals round(cos(2π·a/2^STAGE)·2^15), within 1 LSB. Here a is the address on `addr_o` in the same cycle.
- R5: `tw_im_o` equals round(−sin(2π·a/2^STAGE)·2^15), within 1 LSB, for the same a.
- R6: At address 0 the outputs are exactly `tw_re_o` = 32767 (the +1.0 entry clamped) and `tw_im_o` = 0.
- R7: For STAGE ≥ 2, at address 2^(STAGE-2) the outputs are exactly `tw_re_o` = 0 and `tw_im_o` = −32768.
- R8: With STAGE = 1 the table has one entry. The address stays at 0 and the outputs stay at (32767, 0) under any `en` pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the address on this edge |
| addr_o | output | max(1, STAGE-1) | Current table address |
| tw_re_o | output | DATA_W | Real part of the twiddle, signed fixed point |
| tw_im_o | output | DATA_W | Imaginary part of the twiddle, signed fixed point |

## Verification
A counter that skips, sticks or wraps at the wrong count shows up on `addr_o` at the very next edge. The coefficient pair changes with it in the same cycle, because the read is not registered.

A wrong table entry shows only while the address points at that entry. The bench therefore walks every address of each tested stage many times, under both random and steady enable patterns, and compares each pair with values computed from cos and sin.

The clamped +1.0 entry and the exact −j entry are compared bit for bit. All other entries get a 1-LSB tolerance for rounding. A reset that does not clear the counter is seen on `addr_o` one edge later.

// File: rtl/twd_pkg.sv
package twd_pkg;

   localparam int MAX_STAGE = 11;
   localparam longint ONE_Q30 = 64'sd1073741824;
   localparam longint TWO_PI_Q30 = 64'sd6746518852;

   // Taylor series in Q30 for an angle in [0, pi/2]
   function automatic longint q30_trig(input longint x, input bit want_cos);
      longint x2;
      longint term;
      longint acc;
      int n;
      x2 = (x * x) >>> 30;
      if (want_cos) begin
         term = ONE_Q30;
         n = 0;
      end else begin
         term = x;
         n = 1;
      end
      acc = term;
      for (int i = 0; i < 10; i++) begin
         term = -(((term * x2) >>> 30) / longint'((n + 1) * (n + 2)));
         n = n + 2;
         acc = acc + term;
      end
      return acc;
   endfunction

   // Q30 to signed fixed point with round-half-up and clamping
   function automatic longint q30_to_fix(input longint v, input int dw, input int fw);
      longint r;
      longint hi;
      longint lo;
      r  = (v + (64'sd1 <<< (29 - fw))) >>> (30 - fw);
      hi = (64'sd1 <<< (dw - 1)) - 1;
      lo = -(64'sd1 <<< (dw - 1));
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r;
   endfunction

   // One component of W(k) = exp(-j*2*pi*k/2^s), k < 2^(s-1)
   function automatic longint twiddle_fix(input int k, input int s, input bit want_re,
                                          input int dw, input int fw);
      longint quarter;
      longint x;
      longint c;
      longint sn;
      if (s < 2) begin
         c  = ONE_Q30;
         sn = 0;
      end else begin
         quarter = 64'sd1 <<< (s - 2);
         if (longint'(k) < quarter) begin
            x  = (TWO_PI_Q30 * longint'(k)) >>> s;
            c  = q30_trig(x, 1'b1);
            sn = q30_trig(x, 1'b0);
         end else begin
            x  = (TWO_PI_Q30 * (longint'(k) - quarter)) >>> s;
            c  = -q30_trig(x, 1'b0);
            sn = q30_trig(x, 1'b1);
         end
      end
      return want_re ? q30_to_fix(c, dw, fw) : q30_to_fix(-sn, dw, fw);
   endfunction

endpackage

// File: rtl/twd_addr_ctr.sv
module twd_addr_ctr #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [AW-1:0] addr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst || en) addr <= '0;
         end
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (rst) begin
               addr <= '0;
            end else if (en) begin
               if (addr == LAST) addr <= '0;
               else              addr <= addr + AW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/twd_rom.sv
module twd_rom #(
   parameter int STAGE  = 5,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 15,
   parameter bit IS_RE  = 1'b1,
   parameter int DEPTH  = 16,
   parameter int AW     = 4
) (
   input  logic [AW-1:0]            addr,
   output logic signed [DATA_W-1:0] q
);

   logic signed [DATA_W-1:0] tbl [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         localparam longint VAL = twd_pkg::twiddle_fix(i, STAGE, IS_RE, DATA_W, FRAC_W);
         assign tbl[i] = DATA_W'(VAL);
      end

      if (DEPTH == 1) begin : g_one
         logic unused_addr;
         assign unused_addr = |addr;
         assign q = tbl[0];
      end else begin : g_many
         assign q = tbl[addr];
      end
   endgenerate

endmodule

// File: rtl/twd_seq.sv
module twd_seq #(
   parameter int STAGE  = 5,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 15,
   localparam int DEPTH = 1 << (STAGE - 1),
   localparam int AW    = (STAGE > 1) ? (STAGE - 1) : 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   output logic [AW-1:0]            addr_o,
   output logic signed [DATA_W-1:0] tw_re_o,
   output logic signed [DATA_W-1:0] tw_im_o
);

   generate
      if (STAGE < 1 || STAGE > twd_pkg::MAX_STAGE) begin : g_bad_stage
         $error("twd_seq: STAGE out of range");
      end
      if (FRAC_W != DATA_W - 1 || FRAC_W > 29 || DATA_W < 4) begin : g_bad_width
         $error("twd_seq: unsupported word format");
      end
   endgenerate

   twd_addr_ctr #(
      .DEPTH(DEPTH),
      .AW   (AW)
   ) u_ctr (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .addr(addr_o)
   );

   twd_rom #(
      .STAGE (STAGE),
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .IS_RE (1'b1),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_rom_re (
      .addr(addr_o),
      .q   (tw_re_o)
   );

   twd_rom #(
      .STAGE (STAGE),
      .DATA_W(DATA_W),
      .FRAC_W(FRAC_W),
      .IS_RE (1'b0),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_rom_im (
      .addr(addr_o),
      .q   (tw_im_o)
   );

endmodule

// File: rtl/twd_seq_chk.sv
module twd_seq_chk #(
   parameter int STAGE  = 5,
   parameter int DATA_W = 16,
   localparam int DEPTH = 1 << (STAGE - 1),
   localparam int AW    = (STAGE > 1) ? (STAGE - 1) : 1
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     en,
   input logic [AW-1:0]            addr_o,
   input logic signed [DATA_W-1:0] tw_re_o,
   input logic signed [DATA_W-1:0] tw_im_o
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

   a_r2_reset_zero: assert property (@(posedge clk) rst |=> addr_o == '0);

   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (en && addr_o != LAST) |=> addr_o == $past(addr_o) + AW'(1));

   a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      (en && addr_o == LAST) |=> addr_o == '0);

   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(addr_o) && $stable(tw_re_o) && $stable(tw_im_o)));

   a_r6_entry_zero: assert property (@(posedge clk) disable iff (rst)
      addr_o == '0 |-> (tw_re_o == POS_MAX && tw_im_o == '0));

endmodule

bind twd_seq twd_seq_chk #(
   .STAGE (STAGE),
   .DATA_W(DATA_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .en     (en),
   .addr_o (addr_o),
   .tw_re_o(tw_re_o),
   .tw_im_o(tw_im_o)
);

// File: tb/sim_twd_seq.sv
module sim_twd_seq;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [3:0]         a0;
   logic signed [15:0] re0, im0;
   logic [0:0]         a1;
   logic signed [15:0] re1, im1;
   logic [1:0]         a2;
   logic signed [15:0] re2, im2;

   twd_seq #(.STAGE(5)) u0 (.clk(clk), .rst(rst), .en(en), .addr_o(a0), .tw_re_o(re0), .tw_im_o(im0));
   twd_seq #(.STAGE(1)) u1 (.clk(clk), .rst(rst), .en(en), .addr_o(a1), .tw_re_o(re1), .tw_im_o(im1));
   twd_seq #(.STAGE(3)) u2 (.clk(clk), .rst(rst), .en(en), .addr_o(a2), .tw_re_o(re2), .tw_im_o(im2));

   int n_chk = 0;
   int n_err = 0;
   int e0 = 0;
   int e2 = 0;
   bit done = 1'b0;

   function automatic int exp_tw(input int k, input int s, input bit want_re);
      real ang;
      real v;
      int r;
      ang = 6.283185307179586 * real'(k) / real'(1 << s);
      v = want_re ? $cos(ang) : -$sin(ang);
      v = v * 32768.0;
      if (v >= 0.0) r = $rtoi(v + 0.5);
      else          r = -$rtoi(-v + 0.5);
      if (r > 32767)  r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic chk_near(input string req, input string what, input int act, input int exp, input int tol);
      int d;
      n_chk++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_value(input int k, input int s, input int re_act, input int im_act, input string who);
      if (k == 0) begin
         chk_near("R6", {who, " re at index 0"}, re_act, 32767, 0);
         chk_near("R6", {who, " im at index 0"}, im_act, 0, 0);
      end else if (s >= 2 && k == (1 << (s - 2))) begin
         chk_near("R7", {who, " re at -j entry"}, re_act, 0, 0);
         chk_near("R7", {who, " im at -j entry"}, im_act, -32768, 0);
      end else begin
         chk_near("R4", {who, " real part"}, re_act, exp_tw(k, s, 1'b1), 1);
         chk_near("R5", {who, " imag part"}, im_act, exp_tw(k, s, 1'b0), 1);
      end
   endtask

   task automatic check_all(input string areq);
      chk_near(areq, "u0 address", int'(a0), e0, 0);
      chk_near(areq, "u2 address", int'(a2), e2, 0);
      chk_value(e0, 5, int'(re0), int'(im0), "u0");
      chk_value(e2, 3, int'(re2), int'(im2), "u2");
      // R8: single-entry stage
      chk_near("R8", "u1 address", int'(a1), 0, 0);
      chk_near("R8", "u1 re", int'(re1), 32767, 0);
      chk_near("R8", "u1 im", int'(im1), 0, 0);
   endtask

   // drive at negedge, one rising edge, then check at the next negedge
   task automatic cyc(input bit r, input bit e);
      string areq;
      rst = r;
      en  = e;
      @(posedge clk);
      if (r) begin
         e0 = 0; e2 = 0; areq = "R2";
      end else if (e) begin
         e0 = (e0 + 1) % 16; e2 = (e2 + 1) % 4; areq = "R1";
      end else begin
         areq = "R3";
      end
      @(negedge clk);
      check_all(areq);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd31415));
      @(negedge clk);
      cyc(1'b1, 1'b0);
      cyc(1'b1, 1'b1);
      // R1: walk two full periods of the long table to see both wraps
      for (int i = 0; i < 34; i++) cyc(1'b0, 1'b1);
      // R3: hold with enable low
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
      // R2: reset while enable high, mid-table
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
      cyc(1'b1, 1'b1);
      // alternating enable
      for (int i = 0; i < 20; i++) cyc(1'b0, i[0]);
      // random mix
      for (int i = 0; i < 600; i++) begin
         cyc(($urandom % 60) == 0, ($urandom % 4) != 0);
      end
      finish_run();
   end

endmodule